// File: doc/BRIEF.md
# Dual-Bus Command Word Validator

This block sits behind two redundant serial bus receivers. Each receiver hands it decoded word frames: a one-cycle strobe, a sync-type bit that tells a command-style sync from a data sync, sixteen payload bits, a parity bit and a flag for broken bi-phase coding. For each frame the block decides whether it is a command addressed to this terminal, a data word that belongs to the message in progress, or something to discard.

A command that passes is announced by an active-low strobe of fixed length. The command word is shown on a 16-bit highway while the strobe is low, so the subsystem can decide whether the command is legal. The block registers that verdict, together with its own check for reserved mode codes, at the moment the strobe ends. It then tracks the data words the command is expected to bring in and passes each accepted one to the subsystem with a one-cycle strobe. A command that arrives on the other bus takes over the message in progress.

Top module: `dual_bus_cmd_validator`

## Requirements
- R1: A frame counts as a good word only if `rx_merr` is 0 and the seventeen bits made of its payload and parity bit have odd parity. A command also needs `rx_csync`=1, and a data word needs `rx_csync`=0.
- R2: Bits 15:11 of a command are the terminal address. A command is accepted only when that field equals the latched own address or 5'b11111. Bit 10 is transmit (1) or receive (0), bits 9:5 are the subaddress and bits 4:0 are the word count or mode code.
- R3: Each bus is contiguous for GAP_CYC cycles after it carries a valid word. A frame sampled at most GAP_CYC cycles after a valid word on the same bus follows it contiguously. On a contiguous bus a command is rejected. Any frame that is not valid ends contiguity on its bus.
- R4: A data word is accepted only when it is contiguous on the active bus and words are still expected. It is then presented on `dword` with `dword_stb` high for one cycle, one cycle after the frame.
- R5: An accepted command drives `vcmd_n` low for STRB_CYC cycles, starting the cycle after the frame, and puts the word on `hwy`. While `vcmd_n` is high, `hwy` is zero. A new accepted command restarts the strobe.
- R6: `illegal` is loaded from `ext_illegal` on the clock edge at which `vcmd_n` returns high, and keeps that value until the next such edge.
- R7: A mode command has subaddress 0 or 31. If its mode code is 9 to 15 or 22 to 31, `illegal` is set at the end of the strobe whatever `ext_illegal` is.
- R8: A command accepted on the other bus ends the current message. `act_bus` switches to that bus, and data words on the old bus are no longer accepted.
- R9: `rt_addr` is latched while `rst` is high, and later changes of the pin have no effect. After reset `vcmd_n` is 1, and `hwy`, `illegal` and `seq_active` are 0.
- R10: A receive command (not a mode command) expects as many data words as its word count, with 0 meaning 32. A receive mode command with mode code bit 4 set expects one. Every other command expects none. `seq_active` is high while the strobe is low or words remain.
- R11: If both buses deliver an accepted command in the same cycle, bus 0 wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; own address sampled while high |
| rt_addr | input | 5 | Terminal address pins |
| rx_stb | input | 2 | Frame present, one bit per bus |
| rx_csync | input | 2 | 1 = command sync, 0 = data sync, per bus |
| rx_word | input | 32 | Payload, bus b in bits 16b+15:16b |
| rx_par | input | 2 | Parity bit per bus |
| rx_merr | input | 2 | Bi-phase coding error per bus |
| ext_illegal | input | 1 | Subsystem's illegal-command verdict |
| vcmd_n | output | 1 | Active-low valid-command strobe |
| hwy | output | 16 | Command word during the strobe, else zero |
| illegal | output | 1 | Latched illegal-command flag |
| seq_active | output | 1 | Message in progress |
| act_bus | output | 1 | Bus of the current message |
| dword_stb | output | 1 | Accepted data word pulse |
| dword | output | 16 | Accepted data word |

## Verification
The hardest situations to reach from the ports are the edges of the contiguity window: a data word sampled exactly GAP_CYC cycles after the command must pass, and one sampled a cycle later must fail. The bench shrinks GAP_CYC and STRB_CYC through parameters and places frames by counting idle cycles from the command. Preemption needs a message left half-finished on one bus while a fresh, non-contiguous command arrives on the other. After that, a contiguous data word on each bus shows which of the two messages survived.

// File: rtl/svcv_pkg.sv
package svcv_pkg;

    localparam int NBUS    = 2;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int CNT_W   = 6;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = 5'h1F;

    typedef struct packed {
        logic [ADDR_W-1:0] rta;
        logic              tx;
        logic [4:0]        sa;
        logic [4:0]        wc;
    } cmd_t;

    function automatic logic is_mode(input cmd_t c);
        return (c.sa == 5'd0) || (c.sa == 5'd31);
    endfunction

    function automatic logic is_reserved(input logic [WORD_W-1:0] w);
        cmd_t c;
        c = cmd_t'(w);
        return is_mode(c) &&
               (((c.wc >= 5'd9) && (c.wc <= 5'd15)) || (c.wc >= 5'd22));
    endfunction

    function automatic logic [CNT_W-1:0] words_expected(input logic [WORD_W-1:0] w);
        cmd_t c;
        c = cmd_t'(w);
        if (c.tx)
            return '0;
        else if (is_mode(c))
            return {{(CNT_W-1){1'b0}}, c.wc[4]};
        else if (c.wc == 5'd0)
            return CNT_W'(32);
        else
            return {1'b0, c.wc};
    endfunction

    function automatic logic addr_hit(input logic [WORD_W-1:0] w,
                                      input logic [ADDR_W-1:0] own);
        cmd_t c;
        c = cmd_t'(w);
        return (c.rta == own) || (c.rta == BCAST_ADDR);
    endfunction

endpackage

// File: rtl/svcv_frame_check.sv
module svcv_frame_check
    import svcv_pkg::*;
#(
    parameter int GAP_CYC = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              csync,
    input  logic [WORD_W-1:0] word,
    input  logic              par,
    input  logic              merr,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              cmd_ok,
    output logic              data_ok
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic          recent;
    logic [GW-1:0] gap_cnt;
    logic          coded_ok;

    always_comb begin
        coded_ok = !merr && (^{word, par});
        cmd_ok   = stb && csync && coded_ok && addr_hit(word, own_addr) && !recent;
        data_ok  = stb && !csync && coded_ok && recent;
    end

    // contiguity window per bus
    always_ff @(posedge clk) begin
        if (rst) begin
            recent  <= 1'b0;
            gap_cnt <= '0;
        end else if (stb) begin
            recent  <= cmd_ok || data_ok;
            gap_cnt <= '0;
        end else if (recent) begin
            if (gap_cnt == GW'(GAP_CYC - 1))
                recent <= 1'b0;
            else
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/svcv_seq_tracker.sv
module svcv_seq_tracker
    import svcv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NBUS-1:0]          cmd_ok,
    input  logic [NBUS-1:0]          data_ok,
    input  logic [NBUS*WORD_W-1:0]   words,
    output logic                     start,
    output logic [WORD_W-1:0]        start_word,
    output logic                     act_bus,
    output logic                     pending,
    output logic                     dword_stb,
    output logic [WORD_W-1:0]        dword
);
    logic             sel;
    logic [CNT_W-1:0] left;

    // lowest bus index wins a tie
    always_comb begin
        start = 1'b0;
        sel   = 1'b0;
        for (int i = NBUS - 1; i >= 0; i--) begin
            if (cmd_ok[i]) begin
                start = 1'b1;
                sel   = i[0];
            end
        end
        start_word = words[sel*WORD_W +: WORD_W];
        pending    = (left != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_bus   <= 1'b0;
            left      <= '0;
            dword_stb <= 1'b0;
            dword     <= '0;
        end else begin
            dword_stb <= 1'b0;
            if (start) begin
                act_bus <= sel;
                left    <= words_expected(start_word);
            end else if (data_ok[act_bus] && pending) begin
                left      <= left - 1'b1;
                dword_stb <= 1'b1;
                dword     <= words[act_bus*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/svcv_cmd_strobe.sv
module svcv_cmd_strobe
    import svcv_pkg::*;
#(
    parameter int STRB_CYC = 62
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic              ext_illegal,
    output logic              vcmd_n,
    output logic              strobe_on,
    output logic [WORD_W-1:0] hwy,
    output logic              illegal
);
    localparam int SW = $clog2(STRB_CYC + 1);

    logic [SW-1:0] cnt;
    logic          rsv_q;

    always_comb begin
        strobe_on = (cnt != '0);
        vcmd_n    = !strobe_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            hwy     <= '0;
            rsv_q   <= 1'b0;
            illegal <= 1'b0;
        end else if (start) begin
            cnt   <= SW'(STRB_CYC);
            hwy   <= word;
            rsv_q <= is_reserved(word);
        end else if (strobe_on) begin
            cnt <= cnt - 1'b1;
            if (cnt == SW'(1)) begin
                hwy     <= '0;
                illegal <= ext_illegal || rsv_q;
            end
        end
    end

endmodule

// File: rtl/dual_bus_cmd_validator.sv
module dual_bus_cmd_validator
    import svcv_pkg::*;
#(
    parameter int GAP_CYC  = 250,
    parameter int STRB_CYC = 62
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      rt_addr,
    input  logic [NBUS-1:0]        rx_stb,
    input  logic [NBUS-1:0]        rx_csync,
    input  logic [NBUS*WORD_W-1:0] rx_word,
    input  logic [NBUS-1:0]        rx_par,
    input  logic [NBUS-1:0]        rx_merr,
    input  logic                   ext_illegal,
    output logic                   vcmd_n,
    output logic [WORD_W-1:0]      hwy,
    output logic                   illegal,
    output logic                   seq_active,
    output logic                   act_bus,
    output logic                   dword_stb,
    output logic [WORD_W-1:0]      dword
);
    logic [ADDR_W-1:0] own_addr;
    logic [NBUS-1:0]   cmd_ok;
    logic [NBUS-1:0]   data_ok;
    logic              cmd_start;
    logic [WORD_W-1:0] start_word;
    logic              pending;
    logic              strobe_on;

    always_ff @(posedge clk) begin
        if (rst)
            own_addr <= rt_addr;
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        svcv_frame_check #(.GAP_CYC(GAP_CYC)) u_fc (
            .clk      (clk),
            .rst      (rst),
            .stb      (rx_stb[b]),
            .csync    (rx_csync[b]),
            .word     (rx_word[b*WORD_W +: WORD_W]),
            .par      (rx_par[b]),
            .merr     (rx_merr[b]),
            .own_addr (own_addr),
            .cmd_ok   (cmd_ok[b]),
            .data_ok  (data_ok[b])
        );
    end

    svcv_seq_tracker u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_ok     (cmd_ok),
        .data_ok    (data_ok),
        .words      (rx_word),
        .start      (cmd_start),
        .start_word (start_word),
        .act_bus    (act_bus),
        .pending    (pending),
        .dword_stb  (dword_stb),
        .dword      (dword)
    );

    svcv_cmd_strobe #(.STRB_CYC(STRB_CYC)) u_strb (
        .clk         (clk),
        .rst         (rst),
        .start       (cmd_start),
        .word        (start_word),
        .ext_illegal (ext_illegal),
        .vcmd_n      (vcmd_n),
        .strobe_on   (strobe_on),
        .hwy         (hwy),
        .illegal     (illegal)
    );

    assign seq_active = strobe_on || pending;

endmodule

// File: rtl/svcv_checker.sv
module svcv_checker (
    input logic        clk,
    input logic        rst,
    input logic        vcmd_n,
    input logic [15:0] hwy,
    input logic        illegal,
    input logic        seq_active,
    input logic        dword_stb,
    input logic        cmd_start
);
    // R5: highway quiet outside the strobe
    p_hwy_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        vcmd_n |-> (hwy == 16'h0));

    // R5: an accepted command pulls the strobe low next cycle
    p_start_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !vcmd_n);

    // R6: illegal flag changes only at the strobe's rising edge
    p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$rose(vcmd_n) |-> $stable(illegal));

    // R4: data words are only passed on inside a message
    p_dstb_in_seq_r4: assert property (@(posedge clk) disable iff (rst)
        dword_stb |-> $past(seq_active));

    // R10: strobe low implies a message is active
    p_strobe_seq_r10: assert property (@(posedge clk) disable iff (rst)
        !seq_active |-> vcmd_n);

endmodule

bind dual_bus_cmd_validator svcv_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .vcmd_n     (vcmd_n),
    .hwy        (hwy),
    .illegal    (illegal),
    .seq_active (seq_active),
    .dword_stb  (dword_stb),
    .cmd_start  (cmd_start)
);

// File: tb/dual_bus_cmd_validator_test.sv
module dual_bus_cmd_validator_test;

    localparam int GAP  = 20;
    localparam int STRB = 8;
    localparam logic [4:0] OWN = 5'h0B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rt_addr = OWN;
    logic [1:0]  rx_stb = '0;
    logic [1:0]  rx_csync = '0;
    logic [31:0] rx_word = '0;
    logic [1:0]  rx_par = '0;
    logic [1:0]  rx_merr = '0;
    logic        ext_illegal = 1'b0;
    logic        vcmd_n;
    logic [15:0] hwy;
    logic        illegal;
    logic        seq_active;
    logic        act_bus;
    logic        dword_stb;
    logic [15:0] dword;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dual_bus_cmd_validator #(.GAP_CYC(GAP), .STRB_CYC(STRB)) uut (
        .clk(clk), .rst(rst), .rt_addr(rt_addr), .rx_stb(rx_stb),
        .rx_csync(rx_csync), .rx_word(rx_word), .rx_par(rx_par),
        .rx_merr(rx_merr), .ext_illegal(ext_illegal), .vcmd_n(vcmd_n),
        .hwy(hwy), .illegal(illegal), .seq_active(seq_active),
        .act_bus(act_bus), .dword_stb(dword_stb), .dword(dword)
    );

    function automatic logic [15:0] mk(input logic [4:0] a, input logic tx,
                                       input logic [4:0] sa, input logic [4:0] wc);
        return {a, tx, sa, wc};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; returns at the negedge after the sampling edge
    task automatic send(input int b, input logic cs, input logic [15:0] w,
                        input logic badpar = 1'b0, input logic merr = 1'b0);
        rx_stb[b]             = 1'b1;
        rx_csync[b]           = cs;
        rx_word[b*16 +: 16]   = w;
        rx_par[b]             = (~(^w)) ^ badpar;
        rx_merr[b]            = merr;
        @(negedge clk);
        rx_stb  = '0;
        rx_merr = '0;
    endtask

    task automatic send_both(input logic [15:0] w0, input logic [15:0] w1);
        rx_stb   = 2'b11;
        rx_csync = 2'b11;
        rx_word  = {w1, w0};
        rx_par   = {~(^w1), ~(^w0)};
        @(negedge clk);
        rx_stb = '0;
    endtask

    task automatic t_reset();
        check("R9", "vcmd_n after reset", vcmd_n, 1);
        check("R9", "hwy after reset", hwy, 0);
        check("R9", "illegal after reset", illegal, 0);
        check("R9", "seq_active after reset", seq_active, 0);
    endtask

    task automatic t_basic();
        logic [15:0] c = mk(OWN, 1'b0, 5'd3, 5'd2);
        idle(GAP + 3);
        send(0, 1'b1, c);
        check("R5", "strobe low", vcmd_n, 0);
        check("R5", "hwy carries command", hwy, c);
        check("R10", "seq active", seq_active, 1);
        send(0, 1'b0, 16'h1234);
        check("R4", "first data stb", dword_stb, 1);
        check("R4", "first data", dword, 16'h1234);
        send(0, 1'b0, 16'hABCD);
        check("R4", "second data", dword, 16'hABCD);
        send(0, 1'b0, 16'h5555);
        check("R10", "extra data ignored", dword_stb, 0);
        idle(4);
        check("R5", "strobe last low cycle", vcmd_n, 0);
        idle(1);
        check("R5", "strobe ends", vcmd_n, 1);
        check("R5", "hwy cleared", hwy, 0);
        check("R10", "seq done", seq_active, 0);
    endtask

    task automatic t_addr();
        idle(GAP + 3);
        send(0, 1'b1, mk(5'h1A, 1'b1, 5'd1, 5'd1));
        check("R9", "new pin address ignored", vcmd_n, 1);
        idle(GAP + 3);
        send(0, 1'b1, mk(5'h1C, 1'b1, 5'd1, 5'd1));
        check("R2", "foreign address rejected", vcmd_n, 1);
        idle(GAP + 3);
        send(1, 1'b1, mk(5'h1F, 1'b1, 5'd1, 5'd1));
        check("R2", "broadcast accepted", hwy, mk(5'h1F, 1'b1, 5'd1, 5'd1));
    endtask

    task automatic t_coding();
        logic [15:0] c = mk(OWN, 1'b1, 5'd2, 5'd3);
        idle(GAP + 3);
        send(0, 1'b1, c, 1'b1, 1'b0);
        check("R1", "bad parity rejected", vcmd_n, 1);
        send(0, 1'b1, c, 1'b0, 1'b1);
        check("R1", "coding error rejected", vcmd_n, 1);
        send(0, 1'b0, c);
        check("R1", "data sync not a command", vcmd_n, 1);
        check("R1", "no data stb", dword_stb, 0);
    endtask

    task automatic t_contig_cmd();
        logic [15:0] c1 = mk(OWN, 1'b1, 5'd4, 5'd1);
        logic [15:0] c2 = mk(OWN, 1'b1, 5'd6, 5'd2);
        idle(GAP + 3);
        send(0, 1'b1, c1);
        send(0, 1'b1, c2);
        check("R3", "contiguous command rejected", hwy, c1);
        idle(GAP + 2);
        send(0, 1'b1, c2);
        check("R3", "command after gap accepted", hwy, c2);
    endtask

    task automatic t_contig_data();
        logic [15:0] c = mk(OWN, 1'b0, 5'd7, 5'd3);
        idle(GAP + 3);
        send(0, 1'b1, c);
        idle(GAP - 1);
        send(0, 1'b0, 16'h0F0F);
        check("R3", "data at window edge accepted", dword_stb, 1);
        idle(GAP);
        send(0, 1'b0, 16'hF0F0);
        check("R4", "data past window rejected", dword_stb, 0);
        idle(GAP + 3);
        send(0, 1'b1, c);
        send(0, 1'b0, 16'h1111, 1'b1);
        send(0, 1'b0, 16'h2222);
        check("R3", "invalid frame breaks contiguity", dword_stb, 0);
    endtask

    task automatic t_illegal();
        idle(GAP + 3);
        ext_illegal = 1'b1;
        send(0, 1'b1, mk(OWN, 1'b1, 5'd1, 5'd4));
        idle(STRB - 1);
        check("R6", "not yet latched", illegal, 0);
        idle(1);
        check("R6", "latched at strobe end", illegal, 1);
        ext_illegal = 1'b0;
        idle(GAP + 3);
        send(0, 1'b1, mk(OWN, 1'b1, 5'd1, 5'd4));
        idle(STRB - 1);
        check("R6", "held during next strobe", illegal, 1);
        idle(1);
        check("R6", "cleared at next strobe end", illegal, 0);
        idle(GAP + 3);
        send(0, 1'b1, mk(OWN, 1'b1, 5'd0, 5'd10));
        idle(STRB);
        check("R7", "reserved mode code illegal", illegal, 1);
        idle(GAP + 3);
        send(0, 1'b1, mk(OWN, 1'b1, 5'd31, 5'd17));
        idle(STRB);
        check("R7", "defined mode code legal", illegal, 0);
    endtask

    task automatic t_preempt();
        logic [15:0] c0 = mk(OWN, 1'b0, 5'd4, 5'd4);
        logic [15:0] c1 = mk(OWN, 1'b0, 5'd5, 5'd2);
        idle(GAP + 3);
        send(0, 1'b1, c0);
        send(0, 1'b0, 16'hAAAA);
        check("R8", "data before preempt", dword_stb, 1);
        send(1, 1'b1, c1);
        check("R8", "bus switched", act_bus, 1);
        check("R8", "new command on hwy", hwy, c1);
        send(0, 1'b0, 16'hBBBB);
        check("R8", "old bus data dropped", dword_stb, 0);
        send(1, 1'b0, 16'hCCCC);
        check("R8", "new bus data accepted", dword, 16'hCCCC);
    endtask

    task automatic t_simul();
        logic [15:0] w0 = mk(OWN, 1'b1, 5'd8, 5'd1);
        logic [15:0] w1 = mk(OWN, 1'b1, 5'd9, 5'd1);
        idle(GAP + 3);
        send_both(w0, w1);
        check("R11", "bus 0 wins tie", act_bus, 0);
        check("R11", "bus 0 word on hwy", hwy, w0);
    endtask

    task automatic t_tx();
        idle(GAP + 3);
        send(0, 1'b1, mk(OWN, 1'b1, 5'd2, 5'd5));
        check("R10", "transmit seq active in strobe", seq_active, 1);
        send(0, 1'b0, 16'h7777);
        check("R10", "transmit takes no data", dword_stb, 0);
        idle(STRB);
        check("R10", "transmit seq over", seq_active, 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rt_addr = 5'h1A;
        @(negedge clk);
        t_reset();
        t_basic();
        t_addr();
        t_coding();
        t_contig_cmd();
        t_contig_data();
        t_illegal();
        t_preempt();
        t_simul();
        t_tx();
        finish_run();
    end

    initial begin
        #(200000 * 8);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule